// File: doc/BRIEF.md
# Microcode Sequencer with OR-Merge Dispatch

This block drives the control inputs of a multi-cycle datapath from a fixed microcode table. A control store address register points at the current microword. Each microword carries a control word for the datapath and a sequencing part. The sequencing part holds a successor address and a two-bit selector. The selector says which external value, if any, is merged into that successor address to form the next location. The external values are the instruction opcode, the function code of a register-type instruction, and a flag that says whether two registers are equal.

Branching inside the microprogram needs no adder. The table is laid out so that the successor field always has zeros where the merged value lands, so a bitwise OR picks the target. A fetch word loads the instruction. A second word then dispatches on the opcode, because the opcode only becomes valid after the fetch edge. Each opcode owns a four-word slot in the upper half of the store. Register-type instructions finish in a 32-word region indexed by function code. Conditional branches finish in a pair of words picked by the equality flag.

The microword register sits after the store read. The control word therefore reaches the datapath straight from a flop, and the address shown on `csar_o` always belongs to the word that is being presented.

Top module: `useq_dispatch`

## Requirements
- R1: While `rst_n` is low, every clock edge loads address 0. In the first cycle after reset, `csar_o` is 0 and `ctrl_word_o` is the fetch word 0x00007.
- R2: Word 0 is followed by word 1 regardless of the inputs. Word 1 presents control word 0x00000.
- R3: Word 1 dispatches on the opcode. The next address is 0x100 ORed with the opcode shifted left by two, sampled in the cycle word 1 is presented (opcode 0x05 gives 0x114).
- R4: Opcode 0x00 runs word 0x100 (control 0x00400), then word 0x101 (control 0x00800). Word 0x101 then dispatches on the function code to 0x080 ORed with the 5-bit function value.
- R5: Words 0x080 to 0x09F present 0x08000 ORed with the function value, except function 0x08, which presents 0x00202. Each of these words is followed by word 0.
- R6: Opcode 0x04 presents 0x04000 at 0x110, then goes to word 0x004 ORed with the equality flag (1 = equal). Word 0x004 presents 0x00100 and word 0x005 presents 0x00102. Both are followed by word 0.
- R7: Opcode 0x05 presents 0x04000 at 0x114, then goes to 0x006 ORed with the equality flag. Word 0x006 presents 0x00102 and word 0x007 presents 0x00100. Both are followed by word 0.
- R8: Opcodes 0x08 to 0x0F, 0x23 and 0x2B each run three words at 0x100+4*op+k, for k = 0,1,2. Each word presents 0x10000 + op*256 + k. Words k=0 and k=1 step to k+1; word k=2 returns to word 0.
- R9: Opcode 0x02 presents 0x01002 and opcode 0x03 presents 0x03002, each in a single word followed by word 0.
- R10: Every other location, including the slots of undefined opcodes, presents 0x00000 and is followed by word 0.
- R11: A word whose selector is 00 moves to its successor field exactly, whatever the opcode, function and equality inputs are. In all dispatches, every bit set in the successor field stays set in the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | OP_W (6) | Opcode of the instruction held by the datapath |
| func_i | input | FN_W (5) | Function code of a register-type instruction |
| regs_equal_i | input | 1 | 1 when the two compared registers are equal |
| ctrl_word_o | output | CTRL_W (17) | Control word to the datapath, from the microword register |
| csar_o | output | ADDR_W (9) | Address of the microword currently presented |

## Verification
The bench builds the block with its default widths: a 9-bit address (512 words), a 17-bit control word, a 6-bit opcode and a 5-bit function code. These widths cover the full opcode slot region, every function-code landing word and both branch pairs. Directed instructions walk each populated kind of slot, with JR and ordinary function codes, both equality outcomes for each branch, undefined opcodes, and a reset taken in the middle of an instruction. Long random runs then present fresh inputs every cycle, so any leak of the inputs into a selector-00 step shows up at the ports.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Next-address merge selector carried in every microword
  typedef enum logic [1:0] {
    DEC_NONE   = 2'b00,
    DEC_OPCODE = 2'b01,
    DEC_FUNC   = 2'b10,
    DEC_EQUAL  = 2'b11
  } dec_sel_e;

  // Opcode values that own populated execution slots
  localparam int unsigned OPC_RTYPE = 'h00;
  localparam int unsigned OPC_J     = 'h02;
  localparam int unsigned OPC_JAL   = 'h03;
  localparam int unsigned OPC_BEQ   = 'h04;
  localparam int unsigned OPC_BNE   = 'h05;
  localparam int unsigned OPC_IMM_LO = 'h08;
  localparam int unsigned OPC_IMM_HI = 'h0F;
  localparam int unsigned OPC_LOAD  = 'h23;
  localparam int unsigned OPC_STORE = 'h2B;

  // Function code with its own final word
  localparam int unsigned FN_JREG = 'h08;

  // Control word images
  localparam int unsigned CW_FETCH = 'h00007;
  localparam int unsigned CW_STAY  = 'h00100;
  localparam int unsigned CW_TAKEN = 'h00102;
  localparam int unsigned CW_JREG  = 'h00202;
  localparam int unsigned CW_RREAD = 'h00400;
  localparam int unsigned CW_RALU  = 'h00800;
  localparam int unsigned CW_JUMP  = 'h01002;
  localparam int unsigned CW_JLINK = 'h03002;
  localparam int unsigned CW_CMP   = 'h04000;
  localparam int unsigned CW_RFIN  = 'h08000;
  localparam int unsigned CW_IMM   = 'h10000;

  // Branch-outcome word pairs (low address = registers differ)
  localparam int unsigned BEQ_PAIR = 'h004;
  localparam int unsigned BNE_PAIR = 'h006;

  function automatic bit is_imm_op(input int unsigned op);
    return (op >= OPC_IMM_LO && op <= OPC_IMM_HI) || op == OPC_LOAD || op == OPC_STORE;
  endfunction

endpackage

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OP_W   = 6,
  parameter int unsigned FN_W   = 5
) (
  input  logic [ADDR_W-1:0] nxt_field,
  input  dec_sel_e          dec_field,
  input  logic [OP_W-1:0]   opcode,
  input  logic [FN_W-1:0]   func,
  input  logic              regs_equal,
  output logic [ADDR_W-1:0] or_term,
  output logic [ADDR_W-1:0] target
);

  // Value merged into the successor field; opcode is scaled by four
  function automatic logic [ADDR_W-1:0] merge_source(
    input dec_sel_e        d,
    input logic [OP_W-1:0] op,
    input logic [FN_W-1:0] fn,
    input logic            eq
  );
    case (d)
      DEC_OPCODE: return ADDR_W'({op, 2'b00});
      DEC_FUNC:   return ADDR_W'(fn);
      DEC_EQUAL:  return ADDR_W'(eq);
      default:    return '0;
    endcase
  endfunction

  assign or_term = merge_source(dec_field, opcode, func, regs_equal);
  assign target  = nxt_field | or_term;

endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CTRL_W = 17,
  parameter int unsigned OP_W   = 6,
  parameter int unsigned FN_W   = 5
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CTRL_W-1:0] rd_ctrl,
  output logic [ADDR_W-1:0] rd_next,
  output dec_sel_e          rd_dec
);

  localparam logic [ADDR_W-1:0] EXEC_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] RFIN_BASE = ADDR_W'(1) << (ADDR_W - 2);

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] nxt;
    dec_sel_e          dec;
  } uword_t;

  // Contents of one location, computed from its address
  function automatic uword_t image(input logic [ADDR_W-1:0] a);
    uword_t          w;
    logic [OP_W-1:0] op;
    logic [FN_W-1:0] fn;
    logic [1:0]      k;
    int unsigned     opv;
    w.ctrl = '0;
    w.nxt  = '0;
    w.dec  = DEC_NONE;
    op  = OP_W'(a >> 2);
    opv = int'(op);
    fn  = a[FN_W-1:0];
    k   = a[1:0];
    if (a == '0) begin
      w.ctrl = CTRL_W'(CW_FETCH);
      w.nxt  = ADDR_W'(1);
    end else if (a == ADDR_W'(1)) begin
      w.nxt = EXEC_BASE;
      w.dec = DEC_OPCODE;
    end else if ((a >> 2) == ADDR_W'(1)) begin
      // 4,7: fall through; 5,6: branch taken
      w.ctrl = (k == 2'd1 || k == 2'd2) ? CTRL_W'(CW_TAKEN) : CTRL_W'(CW_STAY);
    end else if ((a >> FN_W) == (RFIN_BASE >> FN_W)) begin
      w.ctrl = (fn == FN_W'(FN_JREG)) ? CTRL_W'(CW_JREG)
                                      : (CTRL_W'(CW_RFIN) | CTRL_W'(fn));
    end else if (a[ADDR_W-1]) begin
      if (opv == OPC_RTYPE) begin
        if (k == 2'd0) begin
          w.ctrl = CTRL_W'(CW_RREAD);
          w.nxt  = a | ADDR_W'(1);
        end else if (k == 2'd1) begin
          w.ctrl = CTRL_W'(CW_RALU);
          w.nxt  = RFIN_BASE;
          w.dec  = DEC_FUNC;
        end
      end else if (k == 2'd0 && opv == OPC_J) begin
        w.ctrl = CTRL_W'(CW_JUMP);
      end else if (k == 2'd0 && opv == OPC_JAL) begin
        w.ctrl = CTRL_W'(CW_JLINK);
      end else if (k == 2'd0 && opv == OPC_BEQ) begin
        w.ctrl = CTRL_W'(CW_CMP);
        w.nxt  = ADDR_W'(BEQ_PAIR);
        w.dec  = DEC_EQUAL;
      end else if (k == 2'd0 && opv == OPC_BNE) begin
        w.ctrl = CTRL_W'(CW_CMP);
        w.nxt  = ADDR_W'(BNE_PAIR);
        w.dec  = DEC_EQUAL;
      end else if (is_imm_op(opv) && k != 2'd3) begin
        w.ctrl = CTRL_W'(CW_IMM) | CTRL_W'(opv << 8) | CTRL_W'(k);
        w.nxt  = (k == 2'd2) ? '0 : a + ADDR_W'(1);
      end
    end
    return w;
  endfunction

  uword_t word;

  always_comb begin
    word    = image(rd_addr);
    rd_ctrl = word.ctrl;
    rd_next = word.nxt;
    rd_dec  = word.dec;
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CTRL_W = 17,
  parameter int unsigned OP_W   = 6,
  parameter int unsigned FN_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic              regs_equal_i,
  output logic [CTRL_W-1:0] ctrl_word_o,
  output logic [ADDR_W-1:0] csar_o
);

  // Microword register: address plus both parts of the word
  logic [ADDR_W-1:0] csar_q;
  logic [CTRL_W-1:0] mir_ctrl_q;
  logic [ADDR_W-1:0] mir_next_q;
  dec_sel_e          mir_dec_q;

  // Named events between the pieces
  logic [ADDR_W-1:0] or_term;
  logic [ADDR_W-1:0] disp_addr;
  logic [ADDR_W-1:0] load_addr;
  logic [CTRL_W-1:0] rd_ctrl;
  logic [ADDR_W-1:0] rd_next;
  dec_sel_e          rd_dec;

  useq_nextaddr #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .FN_W(FN_W)
  ) u_nextaddr (
    .nxt_field (mir_next_q),
    .dec_field (mir_dec_q),
    .opcode    (opcode_i),
    .func      (func_i),
    .regs_equal(regs_equal_i),
    .or_term   (or_term),
    .target    (disp_addr)
  );

  // Reset steers the read to the fetch word
  assign load_addr = rst_n ? disp_addr : '0;

  useq_store #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .OP_W(OP_W), .FN_W(FN_W)
  ) u_store (
    .rd_addr(load_addr),
    .rd_ctrl(rd_ctrl),
    .rd_next(rd_next),
    .rd_dec (rd_dec)
  );

  always_ff @(posedge clk) begin
    csar_q     <= load_addr;
    mir_ctrl_q <= rd_ctrl;
    mir_next_q <= rd_next;
    mir_dec_q  <= rd_dec;
  end

  assign ctrl_word_o = mir_ctrl_q;
  assign csar_o      = csar_q;

endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CTRL_W = 17,
  parameter int unsigned OP_W   = 6,
  parameter int unsigned FN_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   opcode_i,
  input logic [FN_W-1:0]   func_i,
  input logic              regs_equal_i,
  input logic [ADDR_W-1:0] csar_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [ADDR_W-1:0] seq_next,
  input logic [1:0]        seq_dec,
  input logic [ADDR_W-1:0] or_term,
  input logic [ADDR_W-1:0] disp_addr
);

  localparam logic [ADDR_W-1:0] EXEC_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] RFIN_BASE = ADDR_W'(1) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] BEQ_WORD  = EXEC_BASE | ADDR_W'(OPC_BEQ << 2);
  localparam logic [ADDR_W-1:0] BNE_WORD  = EXEC_BASE | ADDR_W'(OPC_BNE << 2);

  AST_RESET_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (csar_q == '0 && ctrl_q == CTRL_W'(CW_FETCH))); // R1

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (csar_q == '0) |=> (csar_q == ADDR_W'(1) && ctrl_q == '0)); // R2

  AST_OPCODE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (csar_q == ADDR_W'(1)) |=> (csar_q == (EXEC_BASE | ADDR_W'({$past(opcode_i), 2'b00})))); // R3

  AST_FUNC_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (csar_q == (EXEC_BASE | ADDR_W'(1))) |=> (csar_q == (RFIN_BASE | ADDR_W'($past(func_i))))); // R4

  AST_RFIN_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    ((csar_q >> FN_W) == (RFIN_BASE >> FN_W)) |=> (csar_q == '0)); // R5

  AST_BEQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (csar_q == BEQ_WORD) |=> (csar_q == (ADDR_W'(BEQ_PAIR) | ADDR_W'($past(regs_equal_i))))); // R6

  AST_BNE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (csar_q == BNE_WORD) |=> (csar_q == (ADDR_W'(BNE_PAIR) | ADDR_W'($past(regs_equal_i))))); // R7

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_dec == 2'b00) |-> (disp_addr == seq_next && or_term == '0)); // R11

  AST_NEXT_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_addr & seq_next) == seq_next)); // R11

endmodule

bind useq_dispatch useq_checker #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .OP_W(OP_W), .FN_W(FN_W)
) u_useq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .opcode_i    (opcode_i),
  .func_i      (func_i),
  .regs_equal_i(regs_equal_i),
  .csar_q      (csar_q),
  .ctrl_q      (mir_ctrl_q),
  .seq_next    (mir_next_q),
  .seq_dec     (mir_dec_q),
  .or_term     (or_term),
  .disp_addr   (disp_addr)
);

// File: tb/useq_dispatch_bench.sv
module useq_dispatch_bench;

  localparam int ADDR_W = 9;
  localparam int CTRL_W = 17;
  localparam int OP_W   = 6;
  localparam int FN_W   = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [OP_W-1:0]   op;
  logic [FN_W-1:0]   fn;
  logic              eq;
  logic [CTRL_W-1:0] ctrl;
  logic [ADDR_W-1:0] csar;

  int errors = 0;
  int checks = 0;
  int exp_addr = 0;
  int prev_addr = -1;
  bit done = 1'b0;

  useq_dispatch #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .OP_W(OP_W), .FN_W(FN_W)
  ) u_useq_dispatch (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode_i    (op),
    .func_i      (fn),
    .regs_equal_i(eq),
    .ctrl_word_o (ctrl),
    .csar_o      (csar)
  );

  // ---- reference model, restated from the requirements ----
  function automatic bit m_imm(input int o);
    return (o >= 8 && o <= 15) || o == 'h23 || o == 'h2B;
  endfunction

  function automatic int m_ctrl(input int a);
    int o;
    int k;
    if (a == 0) return 'h00007;
    if (a == 4 || a == 7) return 'h00100;
    if (a == 5 || a == 6) return 'h00102;
    if (a >= 128 && a < 160) return (a - 128 == 8) ? 'h00202 : 'h08000 + (a - 128);
    if (a >= 256) begin
      o = (a - 256) / 4;
      k = (a - 256) % 4;
      if (o == 0 && k == 0) return 'h00400;
      if (o == 0 && k == 1) return 'h00800;
      if (o == 2 && k == 0) return 'h01002;
      if (o == 3 && k == 0) return 'h03002;
      if ((o == 4 || o == 5) && k == 0) return 'h04000;
      if (m_imm(o) && k < 3) return 'h10000 + o * 256 + k;
    end
    return 0;
  endfunction

  function automatic int m_next(input int a, input int o, input int f, input int e);
    if (a == 0) return 1;
    if (a == 1) return 256 + o * 4;
    if (a == 256) return 257;
    if (a == 257) return 128 + f;
    if (a == 272) return 4 + e;
    if (a == 276) return 6 + e;
    if (a >= 256 && m_imm((a - 256) / 4) && (a - 256) % 4 < 2) return a + 1;
    return 0;
  endfunction

  function automatic string cat(input int a);
    int o;
    o = (a - 256) / 4;
    if (a == 0 || a == 1) return "R2";
    if (a == 4 || a == 5 || a == 272) return "R6";
    if (a == 6 || a == 7 || a == 276) return "R7";
    if (a >= 128 && a < 160) return "R5";
    if (a == 256 || a == 257) return "R4";
    if (a == 264 || a == 268) return "R9";
    if (a >= 256 && m_imm(o) && (a - 256) % 4 < 3) return "R8";
    return "R10";
  endfunction

  function automatic bit m_plain(input int a);
    return !(a == 1 || a == 257 || a == 272 || a == 276);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: check the presented word, drive, advance model
  task automatic run_cycle(input logic [OP_W-1:0] o, input logic [FN_W-1:0] f,
                           input logic e, input bit rnd);
    string at;
    if (prev_addr < 0) at = "R1";
    else if (prev_addr == 1) at = "R3";
    else if (rnd && m_plain(prev_addr)) at = "R11";
    else at = cat(prev_addr);
    check(at, int'(csar), exp_addr, "csar");
    check(cat(exp_addr), int'(ctrl), m_ctrl(exp_addr), "ctrl");
    op = o;
    fn = f;
    eq = e;
    prev_addr = exp_addr;
    exp_addr = m_next(exp_addr, int'(o), int'(f), int'(e));
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [OP_W-1:0] o, input logic [FN_W-1:0] f, input logic e);
    int guard;
    guard = 0;
    run_cycle(o, f, e, 1'b0);
    while (exp_addr != 0 && guard < 12) begin
      run_cycle(o, f, e, 1'b0);
      guard++;
    end
  endtask

  task automatic apply_reset();
    op = '0;
    fn = '0;
    eq = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", int'(csar), 0, "csar in reset");
    check("R1", int'(ctrl), 'h00007, "ctrl in reset");
    rst_n = 1'b1;
    exp_addr = 0;
    prev_addr = -1;
  endtask

  function automatic logic [OP_W-1:0] pick_op();
    int idx;
    idx = int'($urandom % 16);
    case (idx)
      0: return 6'h00;
      1: return 6'h02;
      2: return 6'h03;
      3: return 6'h04;
      4: return 6'h05;
      13: return 6'h23;
      14: return 6'h2B;
      15: return OP_W'($urandom);
      default: return OP_W'(idx + 3);
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    op = '0;
    fn = '0;
    eq = 1'b0;
    void'($urandom(32'd7321));
    @(negedge clk);
    apply_reset();

    // Directed corner cases
    run_instr(6'h05, 5'h00, 1'b0);  // R7 branch taken (0x114 then 6)
    run_instr(6'h05, 5'h00, 1'b1);  // R7 no branch (7)
    run_instr(6'h04, 5'h00, 1'b0);  // R6 no branch (4)
    run_instr(6'h04, 5'h00, 1'b1);  // R6 branch (5)
    run_instr(6'h00, 5'h08, 1'b0);  // R5 register jump word
    run_instr(6'h00, 5'h1F, 1'b1);  // R5 last function word
    run_instr(6'h00, 5'h00, 1'b0);  // R4 function 0
    run_instr(6'h02, 5'h03, 1'b1);  // R9 jump
    run_instr(6'h03, 5'h00, 1'b0);  // R9 jump and link
    run_instr(6'h08, 5'h11, 1'b1);  // R8 lowest immediate op
    run_instr(6'h2B, 5'h00, 1'b0);  // R8 store op
    run_instr(6'h3F, 5'h00, 1'b0);  // R10 undefined top slot
    run_instr(6'h01, 5'h00, 1'b1);  // R10 undefined slot 1

    // R1: reset taken in the middle of a three-word instruction
    run_cycle(6'h23, 5'h00, 1'b0, 1'b0);
    run_cycle(6'h23, 5'h00, 1'b0, 1'b0);
    run_cycle(6'h23, 5'h00, 1'b0, 1'b0);
    apply_reset();

    // Random stream; inputs change every cycle
    for (int i = 0; i < 6000; i++) begin
      logic [FN_W-1:0] rf;
      logic            re;
      rf = FN_W'($urandom);
      re = 1'(($urandom >> 3) & 1);
      run_cycle(pick_op(), rf, re, 1'b1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule